// File: doc/BRIEF.md
# Clock-Synchronous Serial Register Interface

This block is the serial slave port of a display controller. A host frames each access with an active-low chip select and sends bits on a data line, timed by a serial clock. The first byte of every access is a start byte. Its two lowest bits give the direction and the register-select flag. Together these decide where the 16-bit word that follows goes. It can be loaded into the index register, passed on as a register or RAM write, or drawn from the read-data source and shifted back out to the host.

The slave runs on the chip's system clock. It samples chip select, serial clock and serial input through synchronizers and acts on the edges it detects in the serial clock. Input bits are taken on rising edges. Output bits change on falling edges. The rest of the controller sees single-cycle strobes with a captured word. For reads, it sees a request strobe, and the block captures the supplied read word during that strobe.

Top module: `serRegIf`

## Requirements
- R1: Serial input is sampled on rising edges of the serial clock only, most significant bit first, for both the start byte and the 16-bit word.
- R2: A start byte whose bit 1 (direction) is 0 and bit 0 (register select) is 0 makes the next 16 bits an index word: `idxWrStb` pulses once and `idxWord` holds those 16 bits. The upper six start-byte bits have no effect.
- R3: A start byte with bit 1 = 0 and bit 0 = 1 makes the next 16 bits a data word: `dataWrStb` pulses once and `dataWord` holds those 16 bits.
- R4: A start byte with bit 1 = 1 and bit 0 = 1 pulses `rdReqStb` once, right after the start byte. The block captures `rdData` in the cycle `rdReqStb` is high, and no write strobe follows.
- R5: During a read, the captured word is driven on `sdoOut` most significant bit first. Each bit changes on a falling edge of the serial clock, starting with the falling edge after the last start-byte bit. `sdoEn` is high for the whole 16-bit read phase.
- R6: A start byte with bit 1 = 1 and bit 0 = 0 is not a valid access. No strobe follows, and the output stays disabled until chip select goes high.
- R7: When `sdoEn` is low, `sdoOut` is low.
- R8: Chip select going high abandons any partial transfer and clears the bit count. The next byte after chip select falls again is a new start byte, and the abandoned word produces no strobe.
- R9: Within one chip-select frame, a write access keeps accepting further 16-bit words of the same kind, with one strobe per word. A read access ends after one word.
- R10: `idxWrStb`, `dataWrStb` and `rdReqStb` are each one cycle wide, and no two are high in the same cycle.
- R11: After reset, all strobes, `sdoOut`, `sdoEn`, `idxWord` and `dataWord` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select from host, active low |
| sclIn | input | 1 | Serial clock from host |
| sdiIn | input | 1 | Serial data from host |
| sdoOut | output | 1 | Serial data to host, low when not driving |
| sdoEn | output | 1 | High while a read word is being driven |
| idxWrStb | output | 1 | One-cycle strobe: new index word |
| idxWord | output | 16 | Last received index word |
| dataWrStb | output | 1 | One-cycle strobe: new write-data word |
| dataWord | output | 16 | Last received write-data word |
| rdReqStb | output | 1 | One-cycle read request; `rdData` captured in this cycle |
| rdData | input | 16 | Read word supplied by the register/RAM side |

## Verification
The bench uses the default 8-bit start byte, 16-bit word and two-stage synchronizers, with the serial clock eight system cycles per half period. At that size, a walking one through every index bit and a walking zero through every data bit can be run. These sweeps show bit order and placement at every position. All four start-byte codes are covered, with varied upper bits. Reads return words computed from the request count. Abort points fall inside the start byte and inside the data word, and write bursts run within a single frame.

// File: rtl/serRegIf_pkg.sv
`timescale 1ns/1ps
package serRegIf_pkg;

  typedef enum logic [2:0] {
    PH_START,
    PH_WR_IDX,
    PH_WR_DATA,
    PH_READ,
    PH_IGNORE
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic commitIdx;
    logic commitData;
    logic rdReq;
    logic shiftOut;
    logic driveOut;
  } ctrlStb_t;

  // {direction, register select} in the two low start-byte bits
  localparam logic [1:0] CODE_IDX  = 2'b00;
  localparam logic [1:0] CODE_DATA = 2'b01;
  localparam logic [1:0] CODE_READ = 2'b11;

endpackage

// File: rtl/serInSync.sv
`timescale 1ns/1ps
module serInSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclIn,
  input  logic sdiIn,
  output logic sclRise,
  output logic sclFall,
  output logic csActive,
  output logic sdiS
);

  localparam int NUM_IN = 3;
  // bit order {sdi, scl, cs}; chip select resets to inactive
  localparam logic [NUM_IN-1:0] RST_VAL = 3'b001;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic              sclPrev;

  assign rawIn = {sdiIn, sclIn, csN};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {SYNC_STAGES{RST_VAL[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) sclPrev <= 1'b0;
    else       sclPrev <= syncOut[1];
  end

  assign sclRise  = syncOut[1] & ~sclPrev;
  assign sclFall  = ~syncOut[1] & sclPrev;
  assign csActive = ~syncOut[0];
  assign sdiS     = syncOut[2];

endmodule

// File: rtl/serCtrl.sv
`timescale 1ns/1ps
module serCtrl
  import serRegIf_pkg::*;
#(
  parameter int START_BITS = 8,
  parameter int WORD_BITS  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       csActive,
  input  logic [1:0] startCode,
  output ctrlStb_t   stb
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_BITS - 1);
  localparam logic [CNT_W-1:0] WORD_LAST  = CNT_W'(WORD_BITS - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, cntNext;

  always_comb begin
    phaseNext    = phase;
    cntNext      = bitCnt;
    stb          = '0;
    stb.driveOut = (phase == PH_READ);
    if (!csActive) begin
      phaseNext = PH_START;
      cntNext   = '0;
    end else if (sclRise) begin
      unique case (phase)
        PH_START: begin
          stb.shiftIn = 1'b1;
          if (bitCnt == START_LAST) begin
            cntNext = '0;
            unique case (startCode)
              CODE_IDX:  phaseNext = PH_WR_IDX;
              CODE_DATA: phaseNext = PH_WR_DATA;
              CODE_READ: begin
                phaseNext = PH_READ;
                stb.rdReq = 1'b1;
              end
              default:   phaseNext = PH_IGNORE;
            endcase
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        PH_WR_IDX, PH_WR_DATA: begin
          stb.shiftIn = 1'b1;
          if (bitCnt == WORD_LAST) begin
            cntNext        = '0;
            stb.commitIdx  = (phase == PH_WR_IDX);
            stb.commitData = (phase == PH_WR_DATA);
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        PH_READ: begin
          if (bitCnt == WORD_LAST) begin
            cntNext   = '0;
            phaseNext = PH_IGNORE;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sclFall && phase == PH_READ) begin
      stb.shiftOut = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_START;
      bitCnt <= '0;
    end else begin
      phase  <= phaseNext;
      bitCnt <= cntNext;
    end
  end

endmodule

// File: rtl/serDatapath.sv
`timescale 1ns/1ps
module serDatapath
  import serRegIf_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic                 sdiS,
  input  logic [WORD_BITS-1:0] rdData,
  output logic [1:0]           startCode,
  output logic                 idxWrStb,
  output logic [WORD_BITS-1:0] idxWord,
  output logic                 dataWrStb,
  output logic [WORD_BITS-1:0] dataWord,
  output logic                 rdReqStb,
  output logic                 sdoOut,
  output logic                 sdoEn
);

  logic [WORD_BITS-1:0] inShift, nextIn, outShift;
  logic                 sdoReg;

  assign nextIn    = {inShift[WORD_BITS-2:0], sdiS};
  assign startCode = nextIn[1:0];
  assign sdoOut    = sdoEn & sdoReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift   <= '0;
      idxWrStb  <= 1'b0;
      idxWord   <= '0;
      dataWrStb <= 1'b0;
      dataWord  <= '0;
      rdReqStb  <= 1'b0;
    end else begin
      if (stb.shiftIn) inShift <= nextIn;
      idxWrStb  <= stb.commitIdx;
      dataWrStb <= stb.commitData;
      rdReqStb  <= stb.rdReq;
      if (stb.commitIdx)  idxWord  <= nextIn;
      if (stb.commitData) dataWord <= nextIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      sdoReg   <= 1'b0;
      sdoEn    <= 1'b0;
    end else begin
      sdoEn <= stb.driveOut;
      if (rdReqStb)          outShift <= rdData;
      else if (stb.shiftOut) outShift <= {outShift[WORD_BITS-2:0], 1'b0};
      if (!stb.driveOut)     sdoReg <= 1'b0;
      else if (stb.shiftOut) sdoReg <= outShift[WORD_BITS-1];
    end
  end

endmodule

// File: rtl/serRegIf.sv
`timescale 1ns/1ps
module serRegIf
  import serRegIf_pkg::*;
#(
  parameter int START_BITS  = 8,
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclIn,
  input  logic                 sdiIn,
  output logic                 sdoOut,
  output logic                 sdoEn,
  output logic                 idxWrStb,
  output logic [WORD_BITS-1:0] idxWord,
  output logic                 dataWrStb,
  output logic [WORD_BITS-1:0] dataWord,
  output logic                 rdReqStb,
  input  logic [WORD_BITS-1:0] rdData
);

  logic       sclRise, sclFall, csActive, sdiS;
  logic [1:0] startCode;
  ctrlStb_t   stb;

  serInSync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclIn(sclIn), .sdiIn(sdiIn),
    .sclRise(sclRise), .sclFall(sclFall), .csActive(csActive), .sdiS(sdiS)
  );

  serCtrl #(.START_BITS(START_BITS), .WORD_BITS(WORD_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .csActive(csActive), .startCode(startCode), .stb(stb)
  );

  serDatapath #(.WORD_BITS(WORD_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS), .rdData(rdData),
    .startCode(startCode), .idxWrStb(idxWrStb), .idxWord(idxWord),
    .dataWrStb(dataWrStb), .dataWord(dataWord), .rdReqStb(rdReqStb),
    .sdoOut(sdoOut), .sdoEn(sdoEn)
  );

endmodule

// File: rtl/serRegIf_chk.sv
`timescale 1ns/1ps
module serRegIf_chk #(
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 sdoOut,
  input logic                 sdoEn,
  input logic                 idxWrStb,
  input logic [WORD_BITS-1:0] idxWord,
  input logic                 dataWrStb,
  input logic [WORD_BITS-1:0] dataWord,
  input logic                 rdReqStb
);

  logic [2:0] csHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             csHighCnt <= '0;
    else if (!csN)         csHighCnt <= '0;
    else if (csHighCnt != 3'd7) csHighCnt <= csHighCnt + 1'b1;
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idxWrStb, dataWrStb, rdReqStb}));

  p_idx_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    idxWrStb |=> !idxWrStb);

  p_data_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataWrStb |=> !dataWrStb);

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdReqStb |=> !rdReqStb);

  p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdoOut);

  p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csHighCnt >= 3'd5) |-> !(idxWrStb || dataWrStb || rdReqStb || sdoEn));

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !idxWrStb |-> $stable(idxWord));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrStb |-> $stable(dataWord));

  p_rd_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdReqStb |=> sdoEn);

endmodule

bind serRegIf serRegIf_chk #(.WORD_BITS(WORD_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoOut(sdoOut), .sdoEn(sdoEn),
  .idxWrStb(idxWrStb), .idxWord(idxWord), .dataWrStb(dataWrStb),
  .dataWord(dataWord), .rdReqStb(rdReqStb)
);

// File: tb/serRegIf_tb_top.sv
`timescale 1ns/1ps
module serRegIf_tb_top;

  localparam int HALF = 8;  // system cycles per serial half period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclIn = 1'b0;
  logic        sdiIn = 1'b0;
  logic        sdoOut, sdoEn, idxWrStb, dataWrStb, rdReqStb;
  logic [15:0] idxWord, dataWord, rdData;

  int checks = 0, fails = 0;
  int idxCnt = 0, dataCnt = 0, rdCnt = 0;
  int badStb = 0, badSdo = 0;
  logic [15:0] lastIdx = '0, lastData = '0;
  logic prevIdx = 0, prevData = 0, prevRd = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [15:0] pattern(input int n);
    return 16'(n * 16'h3A5D + 16'h1234);
  endfunction

  assign rdData = pattern(rdCnt);

  serRegIf dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclIn(sclIn), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .sdoEn(sdoEn), .idxWrStb(idxWrStb), .idxWord(idxWord),
    .dataWrStb(dataWrStb), .dataWord(dataWord), .rdReqStb(rdReqStb),
    .rdData(rdData)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (idxWrStb)  begin idxCnt++;  lastIdx  = idxWord;  end
      if (dataWrStb) begin dataCnt++; lastData = dataWord; end
      if (rdReqStb)  rdCnt++;
      if ($countones({idxWrStb, dataWrStb, rdReqStb}) > 1) badStb++;
      if ((idxWrStb && prevIdx) || (dataWrStb && prevData) || (rdReqStb && prevRd)) badStb++;
      if (sdoOut && !sdoEn) badSdo++;
      prevIdx = idxWrStb; prevData = dataWrStb; prevRd = rdReqStb;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: low half with data set, sample sdo, rising edge, high half
  task automatic bitXfer(input logic b, output logic so, output logic en);
    sdiIn = b;
    waitClk(HALF);
    so = sdoOut;
    en = sdoEn;
    sclIn = 1'b1;
    waitClk(HALF);
    sclIn = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n,
                          output logic [15:0] rx, output bit allEn, output bit anyOut);
    logic so, en;
    rx = '0; allEn = 1; anyOut = 0;
    for (int i = n - 1; i >= 0; i--) begin
      bitXfer(v[i], so, en);
      rx = {rx[14:0], so};
      if (!en) allEn = 0;
      if (so || en) anyOut = 1;
    end
  endtask

  task automatic frameOpen();
    csN = 1'b0;
    waitClk(4);
  endtask

  task automatic frameClose();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(12);
  endtask

  task automatic writeTx(input logic [7:0] sb, input logic [15:0] w);
    logic [15:0] rx; bit ae, ao;
    frameOpen();
    sendBits({8'h00, sb}, 8, rx, ae, ao);
    sendBits(w, 16, rx, ae, ao);
    frameClose();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] rx, w;
    bit ae, ao;
    int i0, d0, r0;

    waitClk(5);
    rstN = 1'b1;
    waitClk(3);

    // R11: reset state
    check(sdoOut == 0 && sdoEn == 0, "R11", {sdoOut, sdoEn}, 0);
    check(idxWord == 0 && dataWord == 0, "R11", {idxWord, dataWord}, 0);
    check(idxCnt == 0 && dataCnt == 0 && rdCnt == 0, "R11", idxCnt + dataCnt + rdCnt, 0);

    // R1/R2: walking one through every index bit, upper start bits varied
    for (int k = 0; k < 16; k++) begin
      w = 16'(1) << k;
      i0 = idxCnt; d0 = dataCnt;
      writeTx({6'(k * 5 + 3), 2'b00}, w);
      check(idxCnt == i0 + 1, "R2", idxCnt, i0 + 1);
      check(lastIdx == w, "R1", lastIdx, w);
      check(dataCnt == d0, "R2", dataCnt, d0);
    end

    // R1/R3: walking zero through every data bit
    for (int k = 0; k < 16; k++) begin
      w = ~(16'(1) << k);
      i0 = idxCnt; d0 = dataCnt;
      writeTx({6'(~k), 2'b01}, w);
      check(dataCnt == d0 + 1, "R3", dataCnt, d0 + 1);
      check(lastData == w, "R3", lastData, w);
      check(idxCnt == i0, "R3", idxCnt, i0);
    end

    // R4/R5: reads return the captured word MSB first
    for (int n = 0; n < 6; n++) begin
      i0 = idxCnt; d0 = dataCnt; r0 = rdCnt;
      frameOpen();
      sendBits({8'h00, 6'(n * 9 + 1), 2'b11}, 8, rx, ae, ao);
      sendBits(16'hFFFF ^ 16'(n), 16, rx, ae, ao);
      frameClose();
      check(rdCnt == r0 + 1, "R4", rdCnt, r0 + 1);
      check(idxCnt == i0 && dataCnt == d0, "R4", idxCnt + dataCnt, i0 + d0);
      check(rx == pattern(rdCnt), "R5", rx, pattern(rdCnt));
      check(ae, "R5", ae, 1);
    end

    // R6: invalid code, nothing happens and output stays quiet
    for (int n = 0; n < 4; n++) begin
      i0 = idxCnt; d0 = dataCnt; r0 = rdCnt;
      frameOpen();
      sendBits({8'h00, 6'(n * 17), 2'b10}, 8, rx, ae, ao);
      sendBits(16'hA5A5 ^ 16'(n), 16, rx, ae, ao);
      frameClose();
      check(idxCnt == i0 && dataCnt == d0 && rdCnt == r0, "R6",
            idxCnt + dataCnt + rdCnt, i0 + d0 + r0);
      check(!ao, "R6", ao, 0);
    end

    // R8: abort inside the data word, then a fresh index write
    d0 = dataCnt; i0 = idxCnt;
    frameOpen();
    sendBits(16'h0001, 8, rx, ae, ao);
    sendBits(16'h00FF, 7, rx, ae, ao);
    frameClose();
    writeTx(8'h00, 16'hBEEF);
    check(dataCnt == d0, "R8", dataCnt, d0);
    check(idxCnt == i0 + 1 && lastIdx == 16'hBEEF, "R8", lastIdx, 16'hBEEF);

    // R8: abort inside a read start byte
    r0 = rdCnt; i0 = idxCnt;
    frameOpen();
    sendBits(16'h0003, 5, rx, ae, ao);
    frameClose();
    writeTx(8'h00, 16'h1357);
    check(rdCnt == r0, "R8", rdCnt, r0);
    check(idxCnt == i0 + 1 && lastIdx == 16'h1357, "R8", lastIdx, 16'h1357);

    // R9: write burst within one frame
    d0 = dataCnt;
    frameOpen();
    sendBits(16'h0001, 8, rx, ae, ao);
    for (int n = 0; n < 3; n++) begin
      w = 16'hC0DE + 16'(n * 16'h1111);
      sendBits(w, 16, rx, ae, ao);
      waitClk(HALF);
      check(dataCnt == d0 + n + 1, "R9", dataCnt, d0 + n + 1);
      check(lastData == w, "R9", lastData, w);
    end
    frameClose();

    // R9: a read ends after one word, further bits start nothing
    r0 = rdCnt; i0 = idxCnt; d0 = dataCnt;
    frameOpen();
    sendBits(16'h0003, 8, rx, ae, ao);
    sendBits(16'h0000, 16, rx, ae, ao);
    sendBits(16'h0000, 16, rx, ae, ao);
    frameClose();
    check(rdCnt == r0 + 1 && idxCnt == i0 && dataCnt == d0, "R9", rdCnt, r0 + 1);
    check(!ao, "R9", ao, 0);

    // R10 / R7: monitors over the whole run
    check(badStb == 0, "R10", badStb, 0);
    check(badSdo == 0, "R7", badSdo, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule